// File: doc/BRIEF.md
# Interrupt Destination Bitmask Generator

This block turns an inter-processor interrupt command into the set of local interrupt-controller slots that should receive it. The command arrives as two 32-bit words (a low word with the vector, delivery mode, addressing mode, level, trigger and shorthand fields, and a high word with the 8-bit destination) together with a one-cycle write strobe and the physical ID of the sender. Each of the N slots is described by a populated flag, an 8-bit physical ID, an 8-bit logical destination and a 4-bit logical format model.

The block resolves the shorthand override first. When the shorthand leaves the choice to the destination field, it applies physical matching (exact ID or broadcast) or logical matching (flat or cluster model, per slot). For lowest-priority delivery it narrows the set to one slot. An INIT level de-assert command is not delivered. Instead it raises a per-slot arbitration-ID reload strobe. The recipient mask and the decoded command fields are registered and appear one cycle after the strobe.

Top module: `irq_dest_mask`

## Requirements
- R1: One cycle after `cmd_wr_i`, `deliver_o` pulses for one cycle and `vector_o`, `mode_o` and `trig_o` carry low-word bits [7:0], [10:8] and [15]. The INIT de-assert case of R9 is the exception.
- R2: The shorthand in low-word bits [19:18] overrides addressing. 0 uses the destination field, 1 selects only the populated slot whose physical ID equals `self_id_i`, 2 selects every populated slot, and 3 selects every populated slot except the sender's.
- R3: With shorthand 0 and low-word bit 11 clear (physical mode), a destination (high-word bits [31:24]) of 0xFF selects every populated slot. Any other value selects the populated slot(s) whose physical ID equals it, or none.
- R4: In logical mode (bit 11 set), a slot with format 0xF matches when destination AND its logical destination is nonzero.
- R5: In logical mode, a slot with format 0x0 matches when the upper nibbles of destination and logical destination are equal and their lower nibbles share a set bit.
- R6: In logical mode, a slot whose format is neither 0xF nor 0x0 never matches.
- R7: A slot whose populated flag is low never appears in `mask_o` or `arb_reload_o`.
- R8: With delivery mode 3'b001 (lowest priority), `mask_o` holds only the lowest-indexed selected slot, or is zero if none is selected.
- R9: A command with mode 3'b101 (INIT), level bit 14 = 0 and trigger bit 15 = 1 leaves `deliver_o` low and `mask_o` zero. One cycle after the strobe, `arb_reload_o` carries the selected set. INIT with level 1 is delivered normally.
- R10: In a cycle that does not follow a strobe, `deliver_o`, `mask_o` and `arb_reload_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| slot_valid_i | input | N_SLOTS | Slot populated flags |
| slot_phys_id_i | input | 8*N_SLOTS | Physical ID per slot, slot i in bits [8i+7:8i] |
| slot_log_dest_i | input | 8*N_SLOTS | Logical destination per slot |
| slot_fmt_i | input | 4*N_SLOTS | Logical format model per slot |
| self_id_i | input | 8 | Physical ID of the sender |
| cmd_lo_i | input | 32 | Command low word |
| cmd_hi_i | input | 32 | Command high word (destination in [31:24]) |
| cmd_wr_i | input | 1 | Command write strobe |
| deliver_o | output | 1 | Delivery pulse |
| mask_o | output | N_SLOTS | Recipient mask |
| vector_o | output | 8 | Decoded vector |
| mode_o | output | 3 | Decoded delivery mode |
| trig_o | output | 1 | Decoded trigger mode |
| arb_reload_o | output | N_SLOTS | Arbitration-ID reload strobe per slot |

## Verification
Every result is produced by a single register stage, so each output is due exactly one cycle after the edge that samples `cmd_wr_i`. The bench drives the command and strobe on a falling edge, drops the strobe on the next falling edge, and samples the outputs there, half a cycle after the capturing edge. It samples again one cycle later to confirm that the pulse outputs have returned to zero.

// File: rtl/irq_dest_pkg.sv
package irq_dest_pkg;
  localparam int ID_W = 8;
  localparam logic [2:0] DM_LOWEST = 3'b001;
  localparam logic [2:0] DM_INIT   = 3'b101;
  localparam logic [3:0] FMT_FLAT    = 4'hF;
  localparam logic [3:0] FMT_CLUSTER = 4'h0;

  typedef enum logic [1:0] {
    SH_DEST   = 2'd0,
    SH_SELF   = 2'd1,
    SH_ALL    = 2'd2,
    SH_OTHERS = 2'd3
  } shorthand_e;

  typedef struct packed {
    logic [7:0]      vector;
    logic [2:0]      mode;
    logic            logical;
    logic            level;
    logic            trig;
    shorthand_e      sh;
    logic [ID_W-1:0] dest;
  } cmd_t;

  function automatic cmd_t decode_cmd(input logic [31:0] lo, input logic [31:0] hi);
    cmd_t c;
    c.vector  = lo[7:0];
    c.mode    = lo[10:8];
    c.logical = lo[11];
    c.level   = lo[14];
    c.trig    = lo[15];
    c.sh      = shorthand_e'(lo[19:18]);
    c.dest    = hi[31:24];
    return c;
  endfunction
endpackage

// File: rtl/irq_slot_match.sv
module irq_slot_match
  import irq_dest_pkg::*;
(
  input  logic            valid_i,
  input  logic [ID_W-1:0] phys_id_i,
  input  logic [7:0]      log_dest_i,
  input  logic [3:0]      fmt_i,
  input  logic [ID_W-1:0] dest_i,
  input  logic            logical_i,
  input  logic [ID_W-1:0] self_id_i,
  output logic            addr_hit_o,
  output logic            self_hit_o
);
  logic phys_hit, flat_hit, clus_hit;

  assign phys_hit = (dest_i == '1) || (dest_i == phys_id_i);
  assign flat_hit = (fmt_i == FMT_FLAT) && ((dest_i & log_dest_i) != '0);
  assign clus_hit = (fmt_i == FMT_CLUSTER) && (dest_i[7:4] == log_dest_i[7:4])
                    && ((dest_i[3:0] & log_dest_i[3:0]) != '0);

  assign addr_hit_o = valid_i && (logical_i ? (flat_hit || clus_hit) : phys_hit);
  assign self_hit_o = valid_i && (phys_id_i == self_id_i);
endmodule

// File: rtl/irq_first_sel.sv
module irq_first_sel #(
  parameter int N = 8
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_chain
    assign gnt_o[i]  = req_i[i] & ~seen[i];
    assign seen[i+1] = seen[i] | req_i[i];
  end
endmodule

// File: rtl/irq_dest_mask.sv
module irq_dest_mask
  import irq_dest_pkg::*;
#(
  parameter int N_SLOTS = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_SLOTS-1:0]     slot_valid_i,
  input  logic [ID_W*N_SLOTS-1:0] slot_phys_id_i,
  input  logic [8*N_SLOTS-1:0]   slot_log_dest_i,
  input  logic [4*N_SLOTS-1:0]   slot_fmt_i,
  input  logic [ID_W-1:0]        self_id_i,
  input  logic [31:0]            cmd_lo_i,
  input  logic [31:0]            cmd_hi_i,
  input  logic                   cmd_wr_i,
  output logic                   deliver_o,
  output logic [N_SLOTS-1:0]     mask_o,
  output logic [7:0]             vector_o,
  output logic [2:0]             mode_o,
  output logic                   trig_o,
  output logic [N_SLOTS-1:0]     arb_reload_o
);
  cmd_t cmd;
  logic [N_SLOTS-1:0] addr_hit, self_hit, sel, first;
  logic init_deassert;
  logic unused_cmd;

  assign cmd = decode_cmd(cmd_lo_i, cmd_hi_i);
  assign unused_cmd = ^{cmd_lo_i[31:20], cmd_lo_i[17:16], cmd_lo_i[13:12], cmd_hi_i[23:0]};

  for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
    irq_slot_match u_match (
      .valid_i    (slot_valid_i[i]),
      .phys_id_i  (slot_phys_id_i[ID_W*i +: ID_W]),
      .log_dest_i (slot_log_dest_i[8*i +: 8]),
      .fmt_i      (slot_fmt_i[4*i +: 4]),
      .dest_i     (cmd.dest),
      .logical_i  (cmd.logical),
      .self_id_i  (self_id_i),
      .addr_hit_o (addr_hit[i]),
      .self_hit_o (self_hit[i])
    );
  end

  always_comb begin
    unique case (cmd.sh)
      SH_DEST:   sel = addr_hit;
      SH_SELF:   sel = self_hit;
      SH_ALL:    sel = slot_valid_i;
      SH_OTHERS: sel = slot_valid_i & ~self_hit;
      default:   sel = '0;
    endcase
  end

  irq_first_sel #(.N(N_SLOTS)) u_first (.req_i(sel), .gnt_o(first));

  assign init_deassert = (cmd.mode == DM_INIT) && !cmd.level && cmd.trig;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      deliver_o    <= 1'b0;
      mask_o       <= '0;
      vector_o     <= '0;
      mode_o       <= '0;
      trig_o       <= 1'b0;
      arb_reload_o <= '0;
    end else begin
      deliver_o    <= cmd_wr_i && !init_deassert;
      arb_reload_o <= (cmd_wr_i && init_deassert) ? sel : '0;
      if (cmd_wr_i && !init_deassert)
        mask_o <= (cmd.mode == DM_LOWEST) ? first : sel;
      else
        mask_o <= '0;
      if (cmd_wr_i) begin
        vector_o <= cmd.vector;
        mode_o   <= cmd.mode;
        trig_o   <= cmd.trig;
      end
    end
  end

  // R7: recipients always populated
  a_r7_populated_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mask_o | arb_reload_o) & ~$past(slot_valid_i)) == '0);
  // R8: lowest priority yields at most one recipient
  a_r8_single_lowest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deliver_o && mode_o == DM_LOWEST) |-> $onehot0(mask_o));
  // R9: reload strobe and delivery are exclusive
  a_r9_reload_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arb_reload_o != '0) |-> (!deliver_o && mask_o == '0));
  // R10: quiet without a preceding strobe
  a_r10_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(cmd_wr_i) |-> (!deliver_o && mask_o == '0 && arb_reload_o == '0));
  // R1: delivery only follows a strobe
  a_r1_pulse_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deliver_o |-> $past(cmd_wr_i));
endmodule

// File: tb/tb_irq_dest_mask.sv
module tb_irq_dest_mask;
  localparam int N = 8;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic [N-1:0] slot_valid;
  logic [8*N-1:0] phys_id, log_dest;
  logic [4*N-1:0] fmt;
  logic [7:0] self_id;
  logic [31:0] lo, hi;
  logic wr;
  logic deliver; logic [N-1:0] mask, arb; logic [7:0] vec; logic [2:0] mode; logic trig;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  irq_dest_mask #(.N_SLOTS(N)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .slot_valid_i(slot_valid), .slot_phys_id_i(phys_id),
    .slot_log_dest_i(log_dest), .slot_fmt_i(fmt), .self_id_i(self_id),
    .cmd_lo_i(lo), .cmd_hi_i(hi), .cmd_wr_i(wr),
    .deliver_o(deliver), .mask_o(mask), .vector_o(vec), .mode_o(mode), .trig_o(trig),
    .arb_reload_o(arb));

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [7:0] v, input logic [2:0] m, input logic lg,
                                     input logic lv, input logic tg, input logic [1:0] sh);
    return {12'h0, sh, 2'b00, tg, lv, 2'b00, lg, m, v};
  endfunction

  // send a command, sample half a cycle after the capturing edge
  task automatic send(input logic [31:0] l, input logic [7:0] dest);
    @(negedge clk); lo = l; hi = {dest, 24'h0}; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic t_deliver(input string req, input logic [31:0] l, input logic [7:0] dest,
                           input logic [N-1:0] exp_mask);
    send(l, dest);
    chk({req, " deliver"}, {31'h0, deliver}, 32'd1);
    chk({req, " mask"}, {24'h0, mask}, {24'h0, exp_mask});
    chk({req, " arb"}, {24'h0, arb}, 32'h0);
  endtask

  task automatic t_reset;
    chk("R10 reset deliver", {31'h0, deliver}, 0);
    chk("R10 reset mask", {24'h0, mask}, 0);
    chk("R10 reset arb", {24'h0, arb}, 0);
  endtask

  task automatic t_fields;
    send(mk(8'hA5, 3'b000, 1'b0, 1'b1, 1'b1, 2'd0), 8'h23);
    chk("R1 vector", {24'h0, vec}, 32'hA5);
    chk("R1 mode", {29'h0, mode}, 0);
    chk("R1 trig", {31'h0, trig}, 1);
    chk("R1 deliver", {31'h0, deliver}, 1);
    @(negedge clk);
    chk("R10 idle deliver", {31'h0, deliver}, 0);
    chk("R10 idle mask", {24'h0, mask}, 0);
  endtask

  task automatic t_physical;
    t_deliver("R3 phys match", mk(8'h30, 3'b000, 0, 0, 0, 2'd0), 8'h23, 8'h08);
    t_deliver("R3 phys none", mk(8'h30, 3'b000, 0, 0, 0, 2'd0), 8'h99, 8'h00);
    t_deliver("R7 phys unpopulated", mk(8'h30, 3'b000, 0, 0, 0, 2'd0), 8'h26, 8'h00);
    t_deliver("R3 phys broadcast", mk(8'h30, 3'b000, 0, 0, 0, 2'd0), 8'hFF, 8'hBF);
  endtask

  task automatic t_logical;
    t_deliver("R4 flat", mk(8'h40, 3'b000, 1, 0, 0, 2'd0), 8'h06, 8'h0E);
    t_deliver("R5 cluster hit", mk(8'h40, 3'b000, 1, 0, 0, 2'd0), 8'h23, 8'h1B);
    t_deliver("R5 cluster miss", mk(8'h40, 3'b000, 1, 0, 0, 2'd0), 8'h22, 8'h0A);
    t_deliver("R6 R7 other fmt", mk(8'h40, 3'b000, 1, 0, 0, 2'd0), 8'h80, 8'h00);
  endtask

  task automatic t_shorthand;
    t_deliver("R2 self", mk(8'h50, 3'b000, 0, 0, 0, 2'd1), 8'h23, 8'h04);
    t_deliver("R2 all", mk(8'h50, 3'b000, 0, 0, 0, 2'd2), 8'h23, 8'hBF);
    t_deliver("R2 others", mk(8'h50, 3'b000, 0, 0, 0, 2'd3), 8'h23, 8'hBB);
  endtask

  task automatic t_lowest;
    t_deliver("R8 lowest logical", mk(8'h60, 3'b001, 1, 0, 0, 2'd0), 8'h06, 8'h02);
    t_deliver("R8 lowest broadcast", mk(8'h60, 3'b001, 0, 0, 0, 2'd0), 8'hFF, 8'h01);
    t_deliver("R8 lowest empty", mk(8'h60, 3'b001, 0, 0, 0, 2'd0), 8'h99, 8'h00);
  endtask

  task automatic t_init;
    send(mk(8'h00, 3'b101, 0, 1'b0, 1'b1, 2'd2), 8'h00);
    chk("R9 no deliver", {31'h0, deliver}, 0);
    chk("R9 mask zero", {24'h0, mask}, 0);
    chk("R9 reload", {24'h0, arb}, 32'hBF);
    @(negedge clk);
    chk("R10 reload cleared", {24'h0, arb}, 0);
    t_deliver("R9 init assert", mk(8'h00, 3'b101, 0, 1'b1, 1'b1, 2'd3), 8'h00, 8'hBB);
  endtask

  initial begin
    wr = 0; lo = 0; hi = 0; self_id = 8'h22;
    slot_valid = 8'hBF;
    for (int i = 0; i < N; i++) phys_id[8*i +: 8] = 8'h20 + 8'(i);
    log_dest = {8'hFF, 8'hFF, 8'h32, 8'h21, 8'h03, 8'h04, 8'h02, 8'h01};
    fmt      = {4'h5, 4'hF, 4'h0, 4'h0, 4'hF, 4'hF, 4'hF, 4'hF};
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_fields();
    t_physical();
    t_logical();
    t_shorthand();
    t_lowest();
    t_init();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule